// File: doc/BRIEF.md
# Windowed Register Access Translator

This block connects a 32-bit register master to a device register space laid out in two parts. The first part is a small region that is mapped directly. The second is an aperture that can be moved across a much larger offset range. The master issues single read or write requests, each carrying a byte offset. When the offset falls in the low region, or when windowing is switched off, the request goes downstream unchanged at base plus offset. When the offset lies above the low region, it is reached through the aperture. Bits [24:19] of the offset form a window number. The block writes that number, together with an enable flag, into a window-select register. It then issues the data access at the aperture address, which is the aperture start plus the low 19 bits of the offset.

The block keeps the last window number it programmed. A select write is inserted only when the needed window differs from the cached one. After reset the cache holds no valid window, so the first windowed access always programs the select register. The select write and the data access form one uninterrupted sequence. The master gets exactly one response per request. That response carries read data from the data access, never from the select write.

The controller is a four-state machine. In `ST_IDLE` it accepts a request (transition *accept*). It goes to `ST_SELECT` when a windowed request misses the cache (*miss*). It goes straight to `ST_ACCESS` when the request is direct, windowing is off, or the cache hits (*hit/direct*). `ST_SELECT` moves to `ST_ACCESS` once the select write completes (*select done*). `ST_ACCESS` moves to `ST_RESPOND` once the data access completes (*access done*). `ST_RESPOND` returns to `ST_IDLE` when the master takes the response (*response taken*).

Top module: `regwin_xlate`

## Requirements
- R1: After reset, m_ready is 1, d_valid is 0 and r_valid is 0.
- R2: With win_enable=1 and an offset below 0x80000, exactly one downstream access is made, at BASE_ADDR + offset, and no select write is issued.
- R3: With win_enable=0, any offset (including offsets at or above 0x80000) goes downstream unchanged at BASE_ADDR + offset, with no select write.
- R4: A select write goes to BASE_ADDR + 0x310C with write data equal to (1 << EN_BIT) OR window number, where the window number is offset bits [24:19] (EN_BIT is 31 by default).
- R5: A windowed access (win_enable=1, offset >= 0x80000) goes to BASE_ADDR + 0x80000 + (offset AND 0x7FFFF), with the request's direction and write data.
- R6: The first windowed access after reset always issues a select write.
- R7: A windowed access whose window equals the last programmed window issues no select write; a different window issues one, and that window becomes the cached window.
- R8: The downstream port performs one access at a time, in request order. A select write completes before its data access. While d_valid is high and d_ready is low, d_addr, d_write and d_wdata hold steady.
- R9: A read response carries the d_rdata sampled when the data access completed. A write response carries zero.
- R10: Each accepted request produces exactly one response. m_ready stays low from acceptance until the response is taken, and no downstream access is presented while a response is pending.
- R11: Direct accesses and accesses made with windowing disabled leave the cached window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_enable | input | 1 | Windowing on (1) or off (0); held steady while a request is in flight |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Request accepted this cycle when high together with m_valid |
| m_write | input | 1 | 1 = write, 0 = read |
| m_offset | input | AW | Byte offset into the device register space |
| m_wdata | input | DW | Write data |
| r_valid | output | 1 | Response valid |
| r_ready | input | 1 | Master takes the response |
| r_rdata | output | DW | Read data (zero for writes) |
| d_valid | output | 1 | Downstream access valid |
| d_ready | input | 1 | Downstream access completes this cycle |
| d_write | output | 1 | Downstream access direction |
| d_addr | output | AW | Downstream byte address |
| d_wdata | output | DW | Downstream write data |
| d_rdata | input | DW | Downstream read data, valid when d_valid and d_ready are high |

## Verification
The bench goes after the cache in particular. A design that skipped the invalid-after-reset state would omit the first select write. A design that updated the cache on direct or disabled-mode accesses would drop a needed select later. A design that compared against the wrong window bits would either issue redundant selects or land in the wrong window.

It also probes the 0x80000 boundary and offsets with bits set above bit 24. A faulty comparator or mask would show up there as a wrong aperture address.

Randomised stalls on d_ready and r_ready expose any design that changes the downstream request mid-stall, reorders the select after the data access, or returns the select's read data instead of the aperture's.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    // Controller states; order is irrelevant to behaviour.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SELECT,
        ST_ACCESS,
        ST_RESPOND
    } xl_state_t;

endpackage

// File: rtl/regwin_map.sv
// Offset classification and address translation for one request.
module regwin_map #(
    parameter int              AW        = 32,
    parameter int              WIN_SHIFT = 19,
    parameter int              WIN_BITS  = 6,
    parameter logic [AW-1:0]   BASE_ADDR = 32'h1000_0000
) (
    input  logic                 enable,
    input  logic [AW-1:0]        offset,
    output logic                 windowed,
    output logic [WIN_BITS-1:0]  win_num,
    output logic [AW-1:0]        target_addr
);

    localparam logic [AW-1:0] DIRECT_LIMIT = {{(AW-1){1'b0}}, 1'b1} << WIN_SHIFT;
    localparam logic [AW-1:0] APER_MASK    = DIRECT_LIMIT - 1'b1;

    logic [AW-1:0] aperture_addr;
    logic [AW-1:0] direct_addr;

    always_comb begin
        windowed      = enable && (offset >= DIRECT_LIMIT);
        win_num       = offset[WIN_SHIFT +: WIN_BITS];
        direct_addr   = BASE_ADDR + offset;
        aperture_addr = BASE_ADDR + DIRECT_LIMIT + (offset & APER_MASK);
        target_addr   = windowed ? aperture_addr : direct_addr;
    end

endmodule

// File: rtl/regwin_cache.sv
// Remembers the last programmed window; invalid after reset.
module regwin_cache #(
    parameter int WIN_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WIN_BITS-1:0]  load_win,
    input  logic [WIN_BITS-1:0]  probe_win,
    output logic                 hit
);

    logic                valid_q;
    logic [WIN_BITS-1:0] win_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            win_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            win_q   <= load_win;
        end
    end

    always_comb begin
        hit = valid_q && (win_q == probe_win);
    end

endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate #(
    parameter int              AW         = 32,
    parameter int              DW         = 32,
    parameter int              WIN_SHIFT  = 19,
    parameter int              WIN_BITS   = 6,
    parameter int              EN_BIT     = 31,
    parameter logic [AW-1:0]   BASE_ADDR  = 32'h1000_0000,
    parameter logic [AW-1:0]   SEL_OFFSET = 32'h0000_310C
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           win_enable,
    input  logic           m_valid,
    output logic           m_ready,
    input  logic           m_write,
    input  logic [AW-1:0]  m_offset,
    input  logic [DW-1:0]  m_wdata,
    output logic           r_valid,
    input  logic           r_ready,
    output logic [DW-1:0]  r_rdata,
    output logic           d_valid,
    input  logic           d_ready,
    output logic           d_write,
    output logic [AW-1:0]  d_addr,
    output logic [DW-1:0]  d_wdata,
    input  logic [DW-1:0]  d_rdata
);

    import regwin_pkg::*;

    localparam logic [AW-1:0] SEL_ADDR = BASE_ADDR + SEL_OFFSET;
    localparam logic [DW-1:0] EN_FLAG  = {{(DW-1){1'b0}}, 1'b1} << EN_BIT;

    xl_state_t state_q, state_d;

    // Captured request
    logic                req_write_q;
    logic [DW-1:0]       req_wdata_q;
    logic [AW-1:0]       req_addr_q;
    logic [WIN_BITS-1:0] req_win_q;
    logic [DW-1:0]       rdata_q;

    // Classification of the incoming request
    logic                in_windowed;
    logic [WIN_BITS-1:0] in_win;
    logic [AW-1:0]       in_addr;
    logic                cache_hit;
    logic                cache_load;
    logic                accept;

    regwin_map #(
        .AW        (AW),
        .WIN_SHIFT (WIN_SHIFT),
        .WIN_BITS  (WIN_BITS),
        .BASE_ADDR (BASE_ADDR)
    ) u_map (
        .enable      (win_enable),
        .offset      (m_offset),
        .windowed    (in_windowed),
        .win_num     (in_win),
        .target_addr (in_addr)
    );

    regwin_cache #(
        .WIN_BITS (WIN_BITS)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cache_load),
        .load_win  (req_win_q),
        .probe_win (in_win),
        .hit       (cache_hit)
    );

    assign accept     = m_valid && (state_q == ST_IDLE);
    assign cache_load = (state_q == ST_SELECT) && d_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (m_valid) begin
                    if (in_windowed && !cache_hit) begin
                        state_d = ST_SELECT;     // miss
                    end else begin
                        state_d = ST_ACCESS;     // hit/direct
                    end
                end
            end
            ST_SELECT: begin
                if (d_ready) state_d = ST_ACCESS;   // select done
            end
            ST_ACCESS: begin
                if (d_ready) state_d = ST_RESPOND;  // access done
            end
            ST_RESPOND: begin
                if (r_ready) state_d = ST_IDLE;     // response taken
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_write_q <= 1'b0;
            req_wdata_q <= '0;
            req_addr_q  <= '0;
            req_win_q   <= '0;
            rdata_q     <= '0;
        end else begin
            if (accept) begin
                req_write_q <= m_write;
                req_wdata_q <= m_wdata;
                req_addr_q  <= in_addr;
                req_win_q   <= in_win;
            end
            if ((state_q == ST_ACCESS) && d_ready) begin
                rdata_q <= req_write_q ? '0 : d_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        m_ready = 1'b0;
        r_valid = 1'b0;
        d_valid = 1'b0;
        d_write = 1'b0;
        d_addr  = '0;
        d_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                m_ready = 1'b1;
            end
            ST_SELECT: begin
                d_valid = 1'b1;
                d_write = 1'b1;
                d_addr  = SEL_ADDR;
                d_wdata = EN_FLAG | {{(DW-WIN_BITS){1'b0}}, req_win_q};
            end
            ST_ACCESS: begin
                d_valid = 1'b1;
                d_write = req_write_q;
                d_addr  = req_addr_q;
                d_wdata = req_write_q ? req_wdata_q : '0;
            end
            ST_RESPOND: begin
                r_valid = 1'b1;
            end
            default: begin
                m_ready = 1'b0;
            end
        endcase
    end

    assign r_rdata = rdata_q;

    // R8
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_addr) && $stable(d_write) && $stable(d_wdata)));

    // R8
    select_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_ready && d_addr == SEL_ADDR && state_q == ST_SELECT) |=> (d_valid && state_q == ST_ACCESS));

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |=> !m_ready);

    // R9
    response_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_valid) |-> $past(d_valid && d_ready));

    // R7
    cache_primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_load |=> (state_q == ST_ACCESS));

endmodule

// File: tb/regwin_xlate_bench.sv
`timescale 1ns/1ps
module regwin_xlate_bench;

    localparam logic [31:0] BASE    = 32'h1000_0000;
    localparam logic [31:0] SELADDR = 32'h1000_310C;
    localparam logic [31:0] ENFLAG  = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_enable = 1'b1;
    logic        m_valid = 1'b0;
    logic        m_ready;
    logic        m_write = 1'b0;
    logic [31:0] m_offset = '0;
    logic [31:0] m_wdata = '0;
    logic        r_valid;
    logic        r_ready = 1'b1;
    logic [31:0] r_rdata;
    logic        d_valid;
    logic        d_ready = 1'b1;
    logic        d_write;
    logic [31:0] d_addr;
    logic [31:0] d_wdata;
    logic [31:0] d_rdata;

    always #4 clk = ~clk;

    // Downstream device: read data is a fixed function of the address.
    assign d_rdata = d_addr ^ 32'h5A5A_0000;

    regwin_xlate u_regwin_xlate (
        .clk(clk), .rst_n(rst_n), .win_enable(win_enable),
        .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
        .m_offset(m_offset), .m_wdata(m_wdata),
        .r_valid(r_valid), .r_ready(r_ready), .r_rdata(r_rdata),
        .d_valid(d_valid), .d_ready(d_ready), .d_write(d_write),
        .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int resp_seen = 0;
    int resp_expected = 0;

    // Reference model state and expectation queues
    bit          mdl_valid = 0;
    logic [5:0]  mdl_win = '0;
    logic [31:0] q_addr[$];
    bit          q_wr[$];
    logic [31:0] q_wd[$];
    string       q_tag[$];
    logic [31:0] q_resp[$];

    bit          stall_d = 0;
    bit          stall_r = 0;
    logic [15:0] lf = 16'hACE1;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;
    logic [31:0] prev_wd = '0;
    bit          prev_wr = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model(bit wr, logic [31:0] off, logic [31:0] wd);
        bit          windowed;
        logic [5:0]  w;
        logic [31:0] a;
        windowed = win_enable && (off >= 32'h0008_0000);
        w = off[24:19];
        if (windowed && (!mdl_valid || mdl_win != w)) begin
            // R4 R6 R7: select write precedes the data access
            q_addr.push_back(SELADDR); q_wr.push_back(1'b1);
            q_wd.push_back(ENFLAG | {26'd0, w}); q_tag.push_back("R7");
            mdl_valid = 1; mdl_win = w;
        end
        a = windowed ? (BASE + 32'h0008_0000 + (off & 32'h0007_FFFF)) : (BASE + off);
        q_addr.push_back(a); q_wr.push_back(wr); q_wd.push_back(wd);
        q_tag.push_back(windowed ? "R5" : (win_enable ? "R2" : "R3"));
        q_resp.push_back(wr ? 32'h0 : (a ^ 32'h5A5A_0000));
        resp_expected++;
    endtask

    task automatic do_req(bit wr, logic [31:0] off, logic [31:0] wd);
        model(wr, off, wd);
        @(negedge clk);
        m_valid = 1'b1; m_write = wr; m_offset = off; m_wdata = wd;
        while (!m_ready) @(negedge clk);
        @(negedge clk);
        m_valid = 1'b0;
        // R10: busy until the response is taken
        check(!m_ready || resp_seen == resp_expected, "R10", {31'd0, m_ready}, 32'd0);
        while (resp_seen < resp_expected) @(negedge clk);
    endtask

    // Monitor: compares downstream transfers and responses every clock
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_stall) begin
                // R8: request held while stalled
                check(d_valid && d_addr == prev_addr && d_write == prev_wr && d_wdata == prev_wd,
                      "R8", d_addr, prev_addr);
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            d_ready = stall_d ? lf[0] : 1'b1;
            r_ready = stall_r ? lf[3] : 1'b1;
            if (d_valid && d_ready) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R8", d_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea, ew;
                    bit er;
                    string t;
                    ea = q_addr.pop_front(); er = q_wr.pop_front();
                    ew = q_wd.pop_front(); t = q_tag.pop_front();
                    check(d_addr == ea, t, d_addr, ea);
                    check(d_write == er, t, {31'd0, d_write}, {31'd0, er});
                    if (er) check(d_wdata == ew, t, d_wdata, ew);
                end
            end
            prev_stall = d_valid && !d_ready;
            prev_addr = d_addr; prev_wr = d_write; prev_wd = d_wdata;
            if (r_valid) begin
                // R10: no downstream traffic while a response is pending
                check(!d_valid && !m_ready, "R10", {30'd0, d_valid, m_ready}, 32'd0);
            end
            if (r_valid && r_ready) begin
                if (q_resp.size() == 0) begin
                    check(1'b0, "R10", r_rdata, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] er2;
                    er2 = q_resp.pop_front();
                    check(r_rdata == er2, "R9", r_rdata, er2);
                end
                resp_seen++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(m_ready == 1'b1, "R1", {31'd0, m_ready}, 32'd1);
        check(d_valid == 1'b0, "R1", {31'd0, d_valid}, 32'd0);
        check(r_valid == 1'b0, "R1", {31'd0, r_valid}, 32'd0);

        // R2: direct region, both directions, top of region
        do_req(1'b1, 32'h0000_0010, 32'hDEAD_BEEF);
        do_req(1'b0, 32'h0007_FFFC, 32'h0);
        // R6: first windowed access programs the select register
        do_req(1'b0, 32'h0008_0000, 32'h0);
        // R7: same window, no select
        do_req(1'b1, 32'h000F_FFFC, 32'h1111_2222);
        // R11: direct access in between leaves cache alone
        do_req(1'b0, 32'h0000_0400, 32'h0);
        do_req(1'b0, 32'h0008_0040, 32'h0);
        // R7: new window, then highest window, then bits above 24 ignored
        do_req(1'b1, 32'h0123_4568, 32'h3333_4444);
        do_req(1'b0, 32'h01FF_FFFC, 32'h0);
        do_req(1'b0, 32'h8008_0010, 32'h0);
        // R3/R11: windowing disabled, high offset passes through unchanged
        win_enable = 1'b0;
        do_req(1'b1, 32'h0123_4568, 32'h5555_6666);
        do_req(1'b0, 32'h00A0_0000, 32'h0);
        win_enable = 1'b1;
        do_req(1'b0, 32'h0008_0020, 32'h0); // window 1 still cached: no select

        // R8 R9 R10: randomised stalls and offsets
        stall_d = 1; stall_r = 1;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] off;
            seed = seed * 32'd1664525 + 32'd1013904223;
            if (seed[29:28] == 2'd0)
                off = {13'd0, seed[18:2], 2'b00};
            else
                off = {10'd0, seed[10:8] == 3'd0 ? 3'd1 : seed[10:8], seed[27:12], 3'b000} | 32'h0008_0000;
            win_enable = (seed[31:30] != 2'd0);
            do_req(seed[7], off, seed ^ 32'h0F0F_0F0F);
        end
        win_enable = 1'b1;
        stall_d = 0; stall_r = 0;
        repeat (4) @(negedge clk);
        // R10: every request answered, every expected access seen
        check(q_addr.size() == 0, "R10", q_addr.size(), 32'd0);
        check(q_resp.size() == 0, "R10", q_resp.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule